// File: doc/BRIEF.md
# Interrupt Vector Translator with Collision Policy

This block sits between the interrupt sources of a subsystem and the CPU. A peripheral raises a request by presenting a value with a valid strobe; a non-zero value is turned into a CPU interrupt vector, either through a small programmable table of value/vector pairs or, with the table switched off, by using the value itself as the vector. The vector is held as a single pending vector and offered to the CPU on every cycle until the CPU accepts it. Then it is cleared.

If a request produces a different vector while one is still pending, a selectable collision policy settles it. The policy can flag an error, replace the pending vector with the new one, or substitute a fixed vector. A request that misses the table is also an error. The error flag holds until reset, and while it is set the block takes no new requests. All outputs are registered, so the effect of a request shows one clock edge after it is presented.

Top module: `irq_vec_xlate`

## Requirements
- R1: After reset the pending vector is zero, the pending flag is low, the error flag is low and every table entry is cleared.
- R2: A valid request whose value is zero changes neither the pending vector nor the error flag.
- R3: With the table enabled, a non-zero request takes the vector of the lowest-index entry whose value field equals it. Entries whose value field is zero never match. The result is visible after the next clock edge.
- R4: With the table enabled, a non-zero request that matches no entry sets the error flag and latches no vector.
- R5: With the table disabled, the request value, zero-extended to the vector width, becomes the vector.
- R6: A request whose vector equals the vector already pending is dropped, and the pending vector and error flag are unchanged.
- R7: Under policy code 0 or 3 (abort), a different vector that arrives while one is pending sets the error flag and leaves the pending vector unchanged.
- R8: Under policy code 1 (replace), a different vector that arrives while one is pending overwrites it.
- R9: Under policy code 2 (fixed), a different vector that arrives while one is pending is replaced by the configured fixed vector, which is latched instead.
- R10: A pending vector stays on the output until the CPU accepts it. An accept clears the vector to zero on the next edge. The pending flag is high exactly when the vector is non-zero.
- R11: When a request and an accept come in the same cycle, the accept retires the old vector and the request is latched as a fresh vector without any collision handling.
- R12: Once set, the error flag stays high until reset, and while it is high requests are ignored. Accepts are still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe from the peripherals |
| reqValue | input | VAL_W | Request value; zero means no interrupt |
| cpuAccept | input | 1 | CPU takes the pending vector this cycle |
| tblEnable | input | 1 | 1: translate through the table; 0: the value is the vector |
| policy | input | 2 | Collision policy: 0/3 abort, 1 replace, 2 fixed vector |
| fixedVec | input | VEC_W | Vector that policy 2 latches on a collision |
| tblWrEn | input | 1 | Table write strobe |
| tblWrIdx | input | IDX_W | Table entry index to write |
| tblWrVal | input | VAL_W | Value field to write (zero marks the entry unused) |
| tblWrVec | input | VEC_W | Vector field to write |
| pendVec | output | VEC_W | Pending vector; zero when nothing is pending |
| pendValid | output | 1 | High while a vector is pending |
| errFlag | output | 1 | Sticky error for a table miss or an aborting collision |

## Verification
The assertions assume that reset is held for at least one edge before any stimulus and that the policy, fixed-vector and table-enable inputs stay steady for the whole cycle in which they are used. They also assume the hold and clear checks only apply in cycles where no new request competes with the pending vector. The bench changes inputs only on the falling edge. Random phases pick request values mostly from the loaded table, include occasional zero and unmapped values, and reset between phases so that the sticky error does not freeze the rest of the run.

// File: rtl/irq_xlate_pkg.sv
package irq_xlate_pkg;
  typedef enum logic [1:0] {
    POL_ABORT     = 2'd0,
    POL_REPLACE   = 2'd1,
    POL_FIXED     = 2'd2,
    POL_ABORT_ALT = 2'd3
  } policy_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadNew;    // latch translated vector
    logic loadFixed;  // latch fixed collision vector
    logic clearPend;  // CPU accepted the pending vector
  } strobe_t;
endpackage

// File: rtl/irq_xlate_datapath.sv
module irq_xlate_datapath
  import irq_xlate_pkg::*;
#(
  parameter int VAL_W   = 8,
  parameter int VEC_W   = 8,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tblWrEn,
  input  logic [IDX_W-1:0] tblWrIdx,
  input  logic [VAL_W-1:0] tblWrVal,
  input  logic [VEC_W-1:0] tblWrVec,
  input  logic [VAL_W-1:0] reqValue,
  input  logic             tblEnable,
  input  logic [VEC_W-1:0] fixedVec,
  input  strobe_t          strobe,
  output logic [VEC_W-1:0] xlateVec,
  output logic             xlateHit,
  output logic [VEC_W-1:0] pendVec
);
  logic [VAL_W-1:0] tblVal [ENTRIES];
  logic [VEC_W-1:0] tblVec [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic             hit;
  logic [VEC_W-1:0] hitVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tblVal[i] <= '0;
        tblVec[i] <= '0;
      end else if (tblWrEn && tblWrIdx == IDX_W'(i)) begin
        tblVal[i] <= tblWrVal;
        tblVec[i] <= tblWrVec;
      end
    end
    assign matchVec[i] = (tblVal[i] != '0) && (tblVal[i] == reqValue);
  end

  // Lowest index wins
  always_comb begin
    hit    = 1'b0;
    hitVec = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hit    = 1'b1;
        hitVec = tblVec[i];
      end
    end
  end

  assign xlateVec = tblEnable ? hitVec : VEC_W'(reqValue);
  assign xlateHit = tblEnable ? hit : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)                 pendVec <= '0;
    else if (strobe.loadNew)   pendVec <= xlateVec;
    else if (strobe.loadFixed) pendVec <= fixedVec;
    else if (strobe.clearPend) pendVec <= '0;
  end

  assert_fixed_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFixed |=> pendVec == $past(fixedVec));
endmodule

// File: rtl/irq_xlate_ctrl.sv
module irq_xlate_ctrl
  import irq_xlate_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VAL_W-1:0] reqValue,
  input  logic             cpuAccept,
  input  logic [1:0]       policy,
  input  logic [VEC_W-1:0] xlateVec,
  input  logic             xlateHit,
  input  logic [VEC_W-1:0] pendVec,
  output strobe_t          strobe,
  output logic             errFlag
);
  logic fire, busy, hasPend, errSet;

  assign hasPend = pendVec != '0;
  assign fire    = reqValid && (reqValue != '0) && !errFlag;
  assign busy    = hasPend && !cpuAccept;

  always_comb begin
    strobe           = '0;
    strobe.clearPend = cpuAccept && hasPend;
    errSet           = 1'b0;
    if (fire) begin
      if (!xlateHit)               errSet = 1'b1;
      else if (!busy)              strobe.loadNew = 1'b1;
      else if (xlateVec != pendVec) begin
        case (policy_e'(policy))
          POL_REPLACE: strobe.loadNew   = 1'b1;
          POL_FIXED:   strobe.loadFixed = 1'b1;
          default:     errSet           = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       errFlag <= 1'b0;
    else if (errSet) errFlag <= 1'b1;
  end

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  assert_err_blocks_R12: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !cpuAccept |=> $stable(pendVec));
  assert_zero_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqValue == '0 && !cpuAccept |=> $stable(pendVec) && $stable(errFlag));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    hasPend && !cpuAccept && !reqValid |=> $stable(pendVec));
  assert_accept_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    hasPend && cpuAccept && !reqValid |=> pendVec == '0);
  assert_miss_R4: assert property (@(posedge clk) disable iff (!rstN)
    fire && !xlateHit && !cpuAccept |=> errFlag && $stable(pendVec));
  assert_same_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    fire && busy && xlateHit && xlateVec == pendVec |=> $stable(pendVec));
endmodule

// File: rtl/irq_vec_xlate.sv
module irq_vec_xlate
  import irq_xlate_pkg::*;
#(
  parameter int VAL_W   = 8,
  parameter int VEC_W   = 8,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VAL_W-1:0] reqValue,
  input  logic             cpuAccept,
  input  logic             tblEnable,
  input  logic [1:0]       policy,
  input  logic [VEC_W-1:0] fixedVec,
  input  logic             tblWrEn,
  input  logic [IDX_W-1:0] tblWrIdx,
  input  logic [VAL_W-1:0] tblWrVal,
  input  logic [VEC_W-1:0] tblWrVec,
  output logic [VEC_W-1:0] pendVec,
  output logic             pendValid,
  output logic             errFlag
);
  strobe_t          strobe;
  logic [VEC_W-1:0] xlateVec;
  logic             xlateHit;

  irq_xlate_datapath #(.VAL_W(VAL_W), .VEC_W(VEC_W), .ENTRIES(ENTRIES)) dp_i (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
    .tblWrVal(tblWrVal), .tblWrVec(tblWrVec), .reqValue(reqValue),
    .tblEnable(tblEnable), .fixedVec(fixedVec), .strobe(strobe),
    .xlateVec(xlateVec), .xlateHit(xlateHit), .pendVec(pendVec)
  );

  irq_xlate_ctrl #(.VAL_W(VAL_W), .VEC_W(VEC_W)) ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqValue(reqValue),
    .cpuAccept(cpuAccept), .policy(policy), .xlateVec(xlateVec),
    .xlateHit(xlateHit), .pendVec(pendVec), .strobe(strobe), .errFlag(errFlag)
  );

  assign pendValid = pendVec != '0;
endmodule

// File: tb/irq_vec_xlate_tb_top.sv
module irq_vec_xlate_tb_top;
  localparam int VAL_W = 8, VEC_W = 8, ENTRIES = 8, IDX_W = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, cpuAccept = 0, tblEnable = 0, tblWrEn = 0;
  logic [VAL_W-1:0] reqValue = '0, tblWrVal = '0;
  logic [VEC_W-1:0] fixedVec = '0, tblWrVec = '0;
  logic [1:0] policy = 2'd0;
  logic [IDX_W-1:0] tblWrIdx = '0;
  logic [VEC_W-1:0] pendVec;
  logic pendValid, errFlag;

  int checks = 0, fails = 0;
  logic [VAL_W-1:0] mVal [ENTRIES];
  logic [VEC_W-1:0] mVec [ENTRIES];
  logic [VEC_W-1:0] mPend;
  logic mErr;

  always #2 clk = ~clk;

  irq_vec_xlate dut_i (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, logic [VAL_W-1:0] val, bit acc);
    reqValid = v; reqValue = val; cpuAccept = acc; tblWrEn = 0;
  endtask

  // One cycle: model update from pre-edge state, then compare after the edge
  task automatic step(string tag);
    logic [VEC_W-1:0] nPend, vec;
    logic nErr, hit;
    nPend = mPend; nErr = mErr;
    if (cpuAccept && mPend != 0) nPend = '0;
    if (reqValid && reqValue != 0 && !mErr) begin
      hit = !tblEnable; vec = VEC_W'(reqValue);
      if (tblEnable)
        for (int i = ENTRIES - 1; i >= 0; i--)
          if (mVal[i] != 0 && mVal[i] == reqValue) begin hit = 1; vec = mVec[i]; end
      if (!hit) nErr = 1;
      else if (mPend == 0 || cpuAccept) nPend = vec;
      else if (vec != mPend) begin
        case (policy)
          2'd1: nPend = vec;
          2'd2: nPend = fixedVec;
          default: nErr = 1;
        endcase
      end
    end
    if (tblWrEn) begin mVal[tblWrIdx] = tblWrVal; mVec[tblWrIdx] = tblWrVec; end
    @(posedge clk); @(negedge clk);
    mPend = nPend; mErr = nErr;
    chk({tag, " vec"}, 16'(pendVec), 16'(mPend));
    chk({tag, " valid"}, 16'(pendValid), 16'(mPend != 0));
    chk({tag, " err"}, 16'(errFlag), 16'(mErr));
  endtask

  task automatic doReset();
    rstN = 0; drive(0, 0, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1;
    mPend = '0; mErr = 0;
    for (int i = 0; i < ENTRIES; i++) begin mVal[i] = '0; mVec[i] = '0; end
    chk("R1 reset vec", 16'(pendVec), 16'h0);
    chk("R1 reset valid", 16'(pendValid), 16'h0);
    chk("R1 reset err", 16'(errFlag), 16'h0);
  endtask

  task automatic wrTbl(int idx, logic [VAL_W-1:0] val, logic [VEC_W-1:0] vec);
    drive(0, 0, 0);
    tblWrEn = 1; tblWrIdx = IDX_W'(idx); tblWrVal = val; tblWrVec = vec;
    step("R1 table load");
    tblWrEn = 0;
  endtask

  task automatic directedTable();
    wrTbl(0, 8'h05, 8'h20);
    wrTbl(1, 8'h09, 8'h21);
    wrTbl(2, 8'h05, 8'h30);
    wrTbl(3, 8'h00, 8'h40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();
    directedTable();
    tblEnable = 1; policy = 2'd1; fixedVec = 8'h3F;
    drive(1, 8'h00, 0); step("R2 zero req");
    chk("R2 zero ignored", 16'(pendVec), 16'h0);
    drive(1, 8'h05, 0); step("R3 lookup");
    chk("R3 lowest index", 16'(pendVec), 16'h20);
    drive(0, 0, 0); step("R10 hold");
    chk("R10 held", 16'(pendVec), 16'h20);
    drive(1, 8'h05, 0); step("R6 same vec");
    chk("R6 dropped", 16'(pendVec), 16'h20);
    drive(1, 8'h09, 0); step("R8 replace");
    chk("R8 replaced", 16'(pendVec), 16'h21);
    policy = 2'd2;
    drive(1, 8'h05, 0); step("R9 fixed");
    chk("R9 fixed vec", 16'(pendVec), 16'h3F);
    drive(1, 8'h09, 1); step("R11 accept+req");
    chk("R11 fresh", 16'(pendVec), 16'h21);
    chk("R11 no err", 16'(errFlag), 16'h0);
    drive(0, 0, 1); step("R10 accept");
    chk("R10 cleared", 16'(pendVec), 16'h0);
    tblEnable = 0;
    drive(1, 8'h55, 0); step("R5 passthru");
    chk("R5 value as vec", 16'(pendVec), 16'h55);
    drive(0, 0, 1); step("R10 accept2");
    tblEnable = 1;
    drive(1, 8'h07, 0); step("R4 miss");
    chk("R4 err set", 16'(errFlag), 16'h1);
    chk("R4 no latch", 16'(pendVec), 16'h0);
    drive(1, 8'h09, 0); step("R12 blocked");
    chk("R12 still empty", 16'(pendVec), 16'h0);
    drive(0, 0, 0); step("R12 sticky");
    chk("R12 err held", 16'(errFlag), 16'h1);

    doReset();
    directedTable();
    tblEnable = 1; policy = 2'd0;
    drive(1, 8'h05, 0); step("R7 first");
    drive(1, 8'h09, 0); step("R7 abort");
    chk("R7 err", 16'(errFlag), 16'h1);
    chk("R7 kept", 16'(pendVec), 16'h20);
    doReset();
    directedTable();
    policy = 2'd3;
    drive(1, 8'h09, 0); step("R7 alt first");
    drive(1, 8'h05, 0); step("R7 alt abort");
    chk("R7 alt err", 16'(errFlag), 16'h1);

    for (int blk = 0; blk < 8; blk++) begin
      logic [VAL_W-1:0] vals [ENTRIES];
      doReset();
      for (int i = 0; i < ENTRIES; i++) begin
        vals[i] = VAL_W'(i * 3 + 1);
        wrTbl(i, (i == 6) ? 8'h00 : vals[i], VEC_W'($urandom_range(255, 1)));
      end
      tblEnable = 1'($urandom_range(1, 0));
      policy = ($urandom_range(9, 0) == 0) ? 2'd0 : 2'($urandom_range(2, 1));
      fixedVec = VEC_W'($urandom_range(255, 1));
      for (int c = 0; c < 400; c++) begin
        int r;
        logic [VAL_W-1:0] v;
        r = $urandom_range(99, 0);
        if (r < 10) v = '0;
        else if (r < 13) v = VAL_W'($urandom);
        else v = vals[$urandom_range(ENTRIES - 1, 0)];
        drive(1'($urandom_range(1, 0)), v, $urandom_range(9, 0) < 3);
        step("R3 R8 R9 R10 R11 random");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule